// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs one conversion on an external-clock serial ADC (twelve-bit result, eight selectable inputs) over a four-wire link. A host pulses a start input together with an eight-bit control word that holds the channel and configuration bits. The sequencer gates on a serial clock derived from the system clock and shifts the control word out, most significant bit first. It then waits for the converter's one-cycle strobe. On that strobe it turns its single shared data path from drive to listen and clocks in sixteen bits.

The twelve-bit conversion value is cut out of the sixteen received bits by a parameterised window. It is presented with a single-cycle done pulse. If the strobe never arrives, a timeout counter ends the transaction with an error pulse. The serial clock idles low and runs only while a transaction is in flight.

Top module: `serial_adc_seq`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, timeout_o, sclk_o, adc_din_oe_o and link_rx_o are all 0.
- R2: While busy, sclk_o has a period of CLK_DIV system clocks (default 12), high for CLK_DIV/2 and low for CLK_DIV/2. It is 0 whenever busy_o is 0.
- R3: A start_i seen while idle latches ctrl_i. The word leaves on adc_din_o most significant bit first, one bit per serial clock, eight bits in all. adc_din_o changes only while sclk_o is low, so each bit is stable at the rising edge.
- R4: From the start until the strobe is accepted, adc_din_oe_o is 1 and link_rx_o is 0.
- R5: adc_strobe_i is sampled at rising serial-clock edges once the control word has gone out. The first high sample sets link_rx_o to 1 and adc_din_oe_o to 0.
- R6: After the strobe, adc_dout_i is sampled on the next 16 falling serial-clock edges. The first sample is bit 15 of the received word, and the last sample is bit 0.
- R7: At the end of reception, result_o equals bits RES_MSB down to RES_MSB-RES_W+1 of the received word (default bits 14..3). done_o is high for exactly one system clock, and result_o holds until the next done.
- R8: If 16 falling serial-clock edges pass after the control word without an accepted strobe, timeout_o pulses for one clock. The block returns to idle with no done. A strobe accepted after 15 such edges still completes normally.
- R9: A start_i that arrives while busy_o is 1 is ignored. The control word already being sent and the transaction's result are unchanged.
- R10: A start_i presented in the same cycle as done_o is accepted, and busy_o is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (sampled only while idle) |
| ctrl_i | input | CTRL_W | Control word: channel select and configuration |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse, result_o valid |
| result_o | output | RES_W | Conversion value |
| timeout_o | output | 1 | One-cycle pulse, strobe never arrived |
| sclk_o | output | 1 | Serial clock to the converter |
| adc_din_o | output | 1 | Serial data toward the converter |
| adc_din_oe_o | output | 1 | Drive enable for adc_din_o |
| link_rx_o | output | 1 | Data path turned to receive |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_strobe_i | input | 1 | Converter end-of-command strobe |

## Verification
The functions that can fall in one cycle are the completion of one conversion (done_o with its result) and the acceptance of the next start. A second collision is the last counted falling edge of the strobe window, where a late strobe and the timeout meet. The bench presents a new start in the very cycle it observes done_o. It then checks that the first result is intact, that the pulse lasts one cycle, and that the next transaction runs with the new word. The bench also places the model strobe at 15 and then at 16 falling edges past the control word, and expects a completed conversion in the first case and a timeout in the second.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SEND,
        SEQ_WAIT_STB,
        SEQ_RECV
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_edge_t;

    typedef struct packed {
        logic drive_en;
        logic rx_sel;
    } link_dir_t;

    function automatic logic seq_active(seq_state_e s);
        return s != SEQ_IDLE;
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen
    import sadc_pkg::*;
#(
    parameter int unsigned CLK_DIV = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic       sclk_o,
    output sclk_edge_t edge_o
);
    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned CW   = $clog2(CLK_DIV);
    localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
    localparam logic [CW-1:0] FALL_AT = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;
    logic          sclk_q;

    always_comb begin
        edge_o.rise = en && (cnt == RISE_AT);
        edge_o.fall = en && (cnt == FALL_AT);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt <= edge_o.fall ? '0 : cnt + 1'b1;
            if (edge_o.rise)      sclk_q <= 1'b1;
            else if (edge_o.fall) sclk_q <= 1'b0;
        end
    end

    assign sclk_o = sclk_q;

    // checker: length of each high phase
    logic [CW:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst) hi_len <= '0;
        else     hi_len <= sclk_q ? hi_len + 1'b1 : '0;
    end

    AST_SCLK_HALF_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_q) |-> (hi_len == (CW+1)'(HALF))); // R2

endmodule

// File: rtl/sadc_tx_shift.sv
module sadc_tx_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word_i,
    input  logic         shift,
    output logic         bit_o,
    output logic         last_o
);
    localparam int unsigned LW = $clog2(W + 1);
    localparam logic [LW-1:0] FULL = LW'(W);
    localparam logic [LW-1:0] ONE  = LW'(1);

    logic [W-1:0]  sh;
    logic [LW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= word_i;
            left <= FULL;
        end else if (shift && left != '0) begin
            sh   <= {sh[W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign bit_o  = sh[W-1];
    assign last_o = shift && (left == ONE);

    AST_TX_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(sh)); // R9

endmodule

// File: rtl/sadc_rx_window.sv
module sadc_rx_window #(
    parameter int unsigned W     = 16,
    parameter int unsigned RES_W = 12,
    parameter int unsigned MSB   = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic             full_o,
    output logic [RES_W-1:0] result_next_o
);
    localparam int unsigned KW = $clog2(W);
    localparam logic [KW-1:0] K_FIRST = KW'(W - 1 - MSB);
    localparam logic [KW-1:0] K_LAST  = KW'(W - 1 - MSB + RES_W - 1);
    localparam logic [KW-1:0] K_END   = KW'(W - 1);

    logic [KW-1:0]    k;
    logic [RES_W-1:0] res_sh;
    logic             in_win;

    assign in_win = (k >= K_FIRST) && (k <= K_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            k      <= '0;
            res_sh <= '0;
        end else if (shift) begin
            k <= k + 1'b1;
            if (in_win) res_sh <= {res_sh[RES_W-2:0], din};
        end
    end

    assign full_o        = shift && (k == K_END);
    assign result_next_o = (shift && in_win) ? {res_sh[RES_W-2:0], din} : res_sh;

    AST_RX_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (rst || clear)
        (shift && k > K_LAST) |=> $stable(res_sh)); // R7

endmodule

// File: rtl/sadc_strobe_watch.sv
module sadc_strobe_watch
    import sadc_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  sclk_edge_t edge_i,
    input  logic       strobe_i,
    output logic       hit_o,
    output logic       expire_o
);
    localparam int unsigned TW = $clog2(LIMIT);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] waited;

    always_ff @(posedge clk) begin
        if (rst || !arm)      waited <= '0;
        else if (edge_i.fall) waited <= waited + 1'b1;
    end

    assign hit_o    = arm && edge_i.rise && strobe_i;
    assign expire_o = arm && edge_i.fall && (waited == LAST);

    AST_WATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(hit_o && expire_o)); // R8

endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq
    import sadc_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 12,
    parameter int unsigned CTRL_W    = 8,
    parameter int unsigned RX_W      = 16,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned RES_MSB   = 14,
    parameter int unsigned STB_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [RES_W-1:0]  result_o,
    output logic              timeout_o,
    output logic              sclk_o,
    output logic              adc_din_o,
    output logic              adc_din_oe_o,
    output logic              link_rx_o,
    input  logic              adc_dout_i,
    input  logic              adc_strobe_i
);
    seq_state_e       state;
    sclk_edge_t       sedge;
    link_dir_t        dir;
    logic             rx_sel_q, done_q, tmo_q;
    logic [RES_W-1:0] result_q;
    logic             tx_load, tx_shift, tx_last;
    logic             rx_full;
    logic [RES_W-1:0] rx_result;
    logic             stb_hit, stb_expire;

    assign tx_load  = (state == SEQ_IDLE) && start_i;
    assign tx_shift = (state == SEQ_SEND) && sedge.fall;

    sadc_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk   (clk),
        .rst   (rst),
        .en    (seq_active(state)),
        .sclk_o(sclk_o),
        .edge_o(sedge)
    );

    sadc_tx_shift #(.W(CTRL_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (tx_load),
        .word_i(ctrl_i),
        .shift (tx_shift),
        .bit_o (adc_din_o),
        .last_o(tx_last)
    );

    sadc_strobe_watch #(.LIMIT(STB_LIMIT)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .arm     (state == SEQ_WAIT_STB),
        .edge_i  (sedge),
        .strobe_i(adc_strobe_i),
        .hit_o   (stb_hit),
        .expire_o(stb_expire)
    );

    sadc_rx_window #(.W(RX_W), .RES_W(RES_W), .MSB(RES_MSB)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .clear        (stb_hit),
        .shift        ((state == SEQ_RECV) && sedge.fall),
        .din          (adc_dout_i),
        .full_o       (rx_full),
        .result_next_o(rx_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            rx_sel_q <= 1'b0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            unique case (state)
                SEQ_IDLE: if (start_i) begin
                    state    <= SEQ_SEND;
                    rx_sel_q <= 1'b0;
                end
                SEQ_SEND: if (tx_last) state <= SEQ_WAIT_STB;
                SEQ_WAIT_STB: begin
                    if (stb_hit) begin
                        state    <= SEQ_RECV;
                        rx_sel_q <= ~rx_sel_q;
                    end else if (stb_expire) begin
                        state <= SEQ_IDLE;
                        tmo_q <= 1'b1;
                    end
                end
                SEQ_RECV: if (rx_full) begin
                    state    <= SEQ_IDLE;
                    rx_sel_q <= 1'b0;
                    done_q   <= 1'b1;
                    result_q <= rx_result;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        dir.rx_sel   = rx_sel_q;
        dir.drive_en = seq_active(state) && !rx_sel_q;
    end

    assign busy_o       = seq_active(state);
    assign done_o       = done_q;
    assign timeout_o    = tmo_q;
    assign result_o     = result_q;
    assign adc_din_oe_o = dir.drive_en;
    assign link_rx_o    = dir.rx_sel;

    AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !sclk_o); // R2
    AST_DIN_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o) && adc_din_oe_o) |-> $stable(adc_din_o)); // R3
    AST_TURN_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(link_rx_o) |-> $past(adc_strobe_i)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o)); // R7
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!done_o && !link_rx_o)); // R8

endmodule

// File: tb/tb_serial_adc_seq.sv
module tb_serial_adc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  ctrl_i = '0;
    logic        busy_o, done_o, timeout_o, sclk_o, adc_din_o, adc_din_oe_o, link_rx_o;
    logic [11:0] result_o;
    logic        adc_dout_i = 1'b0;
    logic        adc_strobe_i = 1'b0;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    serial_adc_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .ctrl_i(ctrl_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .timeout_o(timeout_o),
        .sclk_o(sclk_o), .adc_din_o(adc_din_o), .adc_din_oe_o(adc_din_oe_o),
        .link_rx_o(link_rx_o), .adc_dout_i(adc_dout_i), .adc_strobe_i(adc_strobe_i)
    );

    // converter model
    int          pos_cnt = 0;
    int          stb_at = 0;
    bit          stb_en = 1;
    bit          rx_on = 0;
    int          rx_idx = 0;
    logic [15:0] mword = '0;
    logic [7:0]  cap = '0;

    always @(posedge sclk_o) begin
        pos_cnt++;
        if (pos_cnt <= 8) cap = {cap[6:0], adc_din_o};
        if (adc_strobe_i) begin rx_on = 1; rx_idx = 15; end
        if (rx_on && rx_idx >= 0) begin adc_dout_i = mword[rx_idx]; rx_idx--; end
    end

    always @(negedge sclk_o) adc_strobe_i = stb_en && (pos_cnt == 8 + stb_at);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_arm(input logic [15:0] w, input int delay, input bit en);
        pos_cnt = 0; rx_on = 0; mword = w; stb_at = delay; stb_en = en; cap = '0;
    endtask

    task automatic launch(input logic [7:0] c);
        @(negedge clk);
        start_i = 1'b1; ctrl_i = c;
        @(negedge clk);
        start_i = 1'b0; ctrl_i = 8'h00;
    endtask

    // waits for done or timeout; optional injected start while busy, optional start on done
    task automatic wait_end(input int inject_at, input bit chain, input logic [7:0] next_c,
                            input logic [15:0] next_w,
                            output bit got_done, output bit got_tmo,
                            output logic [11:0] res, output int oe_bad, output bit saw_rx);
        got_done = 0; got_tmo = 0; res = '0; oe_bad = 0; saw_rx = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (busy_o && !link_rx_o && !adc_din_oe_o) oe_bad++;
            if (link_rx_o && !adc_din_oe_o) saw_rx = 1;
            if (k == inject_at) begin start_i = 1'b1; ctrl_i = 8'h33; end
            if (done_o || timeout_o) begin
                got_done = done_o; got_tmo = timeout_o; res = result_o;
                if (chain) begin
                    model_arm(next_w, 0, 1);
                    start_i = 1'b1; ctrl_i = next_c;
                end
                break;
            end
        end
        if (!chain) begin @(negedge clk); start_i = 1'b0; end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy_o, 0);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 timeout", timeout_o, 0);
        chk("R1 oe", adc_din_oe_o, 0);
        chk("R1 link", link_rx_o, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_basic;
        bit d, t, rx; logic [11:0] r; int ob; int hi, lo;
        model_arm(16'h5A3C, 0, 1);
        launch(8'hF1);
        chk("R4 oe at start", adc_din_oe_o, 1);
        while (!sclk_o) @(negedge clk);
        hi = 0; while (sclk_o) begin hi++; @(negedge clk); end
        lo = 0; while (!sclk_o) begin lo++; @(negedge clk); end
        chk("R2 high phase", hi, 6);
        chk("R2 low phase", lo, 6);
        wait_end(-1, 0, 8'h00, 16'h0, d, t, r, ob, rx);
        chk("R3 control word", cap, 8'hF1);
        chk("R4 drive before strobe", ob, 0);
        chk("R5 turned to receive", rx, 1);
        chk("R6 R7 done", d, 1);
        chk("R7 result window", r, 12'hB47);
        chk("R7 done width", done_o, 0);
        chk("R7 result held", result_o, 12'hB47);
        chk("R2 sclk idle", sclk_o, 0);
        chk("R5 link cleared", link_rx_o, 0);
    endtask

    task automatic t_patterns;
        bit d, t, rx; logic [11:0] r; int ob;
        logic [15:0] words [4] = '{16'hFFFF, 16'h0000, 16'h8001, 16'h7FF8};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] c;
            c = {1'b1, 3'(i * 2 + 1), 4'hF};
            model_arm(words[i], 0, 1);
            launch(c);
            wait_end(-1, 0, 8'h00, 16'h0, d, t, r, ob, rx);
            chk("R3 channel word", cap, c);
            chk("R6 pattern done", d, 1);
            chk("R6 R7 pattern result", r, words[i][14:3]);
        end
    endtask

    task automatic t_late_ok;
        bit d, t, rx; logic [11:0] r; int ob;
        model_arm(16'h1234, 15, 1);
        launch(8'hC7);
        wait_end(-1, 0, 8'h00, 16'h0, d, t, r, ob, rx);
        chk("R8 strobe after 15 edges accepted", d, 1);
        chk("R8 no timeout at 15", t, 0);
        chk("R8 late result", r, 12'h246);
    endtask

    task automatic t_timeout;
        bit d, t, rx; logic [11:0] r; int ob;
        model_arm(16'hABCD, 16, 1);
        launch(8'h9F);
        wait_end(-1, 0, 8'h00, 16'h0, d, t, r, ob, rx);
        chk("R8 timeout pulse", t, 1);
        chk("R8 no done", d, 0);
        chk("R8 no receive turn", rx, 0);
        chk("R8 back to idle", busy_o, 0);
        chk("R8 timeout width", timeout_o, 0);
        repeat (30) @(negedge clk);
        chk("R8 late strobe ignored", busy_o, 0);
        chk("R8 result unchanged", result_o, 12'h246);
    endtask

    task automatic t_busy_start;
        bit d, t, rx; logic [11:0] r; int ob;
        model_arm(16'h6E5A, 2, 1);
        launch(8'hB3);
        wait_end(30, 0, 8'h00, 16'h0, d, t, r, ob, rx);
        chk("R9 word not reloaded", cap, 8'hB3);
        chk("R9 result intact", r, 12'hDCB);
        repeat (3) @(negedge clk);
        chk("R9 no extra transaction", busy_o, 0);
    endtask

    task automatic t_chain;
        bit d, t, rx; logic [11:0] r; int ob;
        model_arm(16'h0FF0, 0, 1);
        launch(8'hA5);
        wait_end(-1, 1, 8'hE2, 16'hF00F, d, t, r, ob, rx);
        chk("R10 first done", d, 1);
        chk("R10 first result", r, 12'h1FE);
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 start accepted on done", busy_o, 1);
        wait_end(-1, 0, 8'h00, 16'h0, d, t, r, ob, rx);
        chk("R10 second word", cap, 8'hE2);
        chk("R10 second result", r, 12'hE01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_patterns();
        t_late_ok();
        t_timeout();
        t_busy_start();
        t_chain();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule